// File: doc/BRIEF.md
# Channel Event Interrupt Aggregator

This block collects completion events from a four-channel serial controller and turns them into one level-sensitive interrupt line for the host. Each channel reports a transmit-done pulse and a receive-done pulse. Each pulse sets its own bit in a sticky status register. The host reads that register to learn which channels need attention. It acknowledges events by writing ones to the bits it has handled, and it chooses which events may raise the line through a mask register.

The line goes high at once on any evaluation that finds a status bit that is both pending and unmasked. It goes low in a deliberately lazy way. Every evaluation that finds nothing pending advances a small clearing counter. The line drops only on the evaluation that brings this counter to three, and the counter then restarts from zero.

Three things trigger an evaluation: an event pulse, a write to the status register, and a write to the mask register. Each evaluation looks at the register values as they are after the cycle's updates.

Top module: `chan_irq_ctrl`

## Requirements
- R1: A pulse on `tx_done[n]` sets status bit n (bit 0 for channel 0 up to bit 3 for channel 3).
- R2: A pulse on `rx_done[n]` sets status bit 4+n (bits 4 to 7).
- R3: At byte offset 0x00 a read returns the status register. A write clears each status bit whose written data bit is one and leaves the others unchanged.
- R4: At byte offset 0x10 sits an 8-bit mask register that reads back the value last written. Mask bit k enables status bit k.
- R5: An evaluation takes place in any cycle that has an event pulse, a write to offset 0x00 or a write to offset 0x10. If the updated status AND the updated mask is nonzero, `irq` is 1 after that clock edge.
- R6: An evaluation that finds nothing pending adds one to the clearing counter. When the counter reaches 3, `irq` goes to 0 and the counter returns to 0. An evaluation that asserts `irq` leaves the counter unchanged.
- R7: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: After reset, status, mask and the clearing counter are zero and `irq` is 0.
- R9: Read data bits 31..8 are always zero. A read of any other offset returns zero. A write to any other offset changes no register and triggers no evaluation.
- R10: In a cycle with no evaluation, `irq` and the clearing counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | NUM_CHAN (4) | One-cycle transmit-completion pulse per channel |
| rx_done | input | NUM_CHAN (4) | One-cycle receive-completion pulse per channel |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt line toward the host |

## Verification
The bench first targets the lazy drop of the line. It runs sequences of two non-pending evaluations separated by idle cycles and read-only cycles, and then a third evaluation. A design that drops the line at once, or that counts idle cycles as evaluations, would show `irq` low too early. It also leaves the counter at one or two across a phase in which the line is asserted. A design that resets the counter there would keep `irq` high one evaluation too long. A write of all-zero data to the status register must still count as an evaluation. Further cases are a clear and an event on the same bit in the same cycle, where a clear-wins design would lose the bit, and writes to an unmapped offset that must not count as evaluations. The last case is mask writes with upper data bits set, which must read back truncated.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

   // Bit index of the transmit-done flag of a channel
   function automatic int tx_bit_idx(input int chan);
      return chan;
   endfunction

   // Bit index of the receive-done flag of a channel, above all transmit flags
   function automatic int rx_bit_idx(input int chan, input int num_chan);
      return num_chan + chan;
   endfunction

   // Decoded register access for one cycle
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_STATUS = 2'd1,
      ACC_MASK   = 2'd2
   } acc_sel_e;

endpackage

// File: rtl/chan_irq_status.sv
module chan_irq_status #(
   parameter int NUM_CHAN = 4,
   localparam int EV_W    = 2 * NUM_CHAN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NUM_CHAN-1:0] tx_done,
   input  logic [NUM_CHAN-1:0] rx_done,
   input  logic            clr_en,
   input  logic [EV_W-1:0] clr_bits,
   output logic [EV_W-1:0] st_q,
   output logic [EV_W-1:0] st_d,
   output logic            any_evt
);
   import chan_irq_pkg::*;

   logic [EV_W-1:0] set_vec;

   // Map each channel's pulses onto their status positions
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_map
      assign set_vec[tx_bit_idx(c)]           = tx_done[c];
      assign set_vec[rx_bit_idx(c, NUM_CHAN)] = rx_done[c];
   end

   // Per-bit sticky cell: an event outranks a clear of the same cycle
   for (genvar b = 0; b < EV_W; b++) begin : g_cell
      always_comb begin
         if (set_vec[b])
            st_d[b] = 1'b1;
         else if (clr_en && clr_bits[b])
            st_d[b] = 1'b0;
         else
            st_d[b] = st_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= st_d;
   end

   assign any_evt = |set_vec;

   // R7: every bit pulsed in a cycle is set afterwards, whatever was cleared
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((st_q & $past(set_vec)) == $past(set_vec)));

   // R3: cleared bits without a competing event read zero afterwards
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((st_q & $past(clr_bits & ~set_vec)) == '0));

endmodule

// File: rtl/chan_irq_mask.sv
module chan_irq_mask #(
   parameter int EV_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [EV_W-1:0] wr_bits,
   output logic [EV_W-1:0] mk_q,
   output logic [EV_W-1:0] mk_d
);

   assign mk_d = wr_en ? wr_bits : mk_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mk_q <= '0;
      else
         mk_q <= mk_d;
   end

   // R4: a mask write is held verbatim
   a_r4_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mk_q == $past(wr_bits)));

endmodule

// File: rtl/chan_irq_line.sv
module chan_irq_line #(
   parameter int CLR_THRESH = 3,
   localparam int CNT_W     = $clog2(CLR_THRESH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eval,
   input  logic pend,
   output logic irq
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else if (eval) begin
         if (pend) begin
            irq <= 1'b1;
         end else if (cnt_inc == CNT_W'(CLR_THRESH)) begin
            irq   <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

   // R5: a pending evaluation raises the line
   a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && pend) |=> irq);

   // R6: the line only falls after an empty evaluation
   a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(eval && !pend));

   // R6: the counter never rests at the threshold
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(CLR_THRESH));

   // R10: no evaluation, no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> ($stable(irq) && $stable(cnt_q)));

endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl #(
   parameter int          NUM_CHAN   = 4,
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 8,
   parameter int          CLR_THRESH = 3,
   parameter logic [7:0]  STAT_OFF   = 8'h00,
   parameter logic [7:0]  MASK_OFF   = 8'h10,
   localparam int         EV_W       = 2 * NUM_CHAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CHAN-1:0] tx_done,
   input  logic [NUM_CHAN-1:0] rx_done,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   import chan_irq_pkg::*;

   initial begin
      assert (DATA_W > EV_W) else $error("DATA_W must exceed the event count");
      assert (CLR_THRESH >= 1) else $error("CLR_THRESH must be at least 1");
      assert (ADDR_W >= 8) else $error("ADDR_W too narrow for the offsets");
   end

   acc_sel_e        sel;
   logic            st_wr, mk_wr, any_evt, eval, pend;
   logic [EV_W-1:0] st_q, st_d, mk_q, mk_d;
   logic            unused_wdata;

   always_comb begin
      if (reg_addr == ADDR_W'(STAT_OFF))
         sel = ACC_STATUS;
      else if (reg_addr == ADDR_W'(MASK_OFF))
         sel = ACC_MASK;
      else
         sel = ACC_NONE;
   end

   assign st_wr        = reg_wr && (sel == ACC_STATUS);
   assign mk_wr        = reg_wr && (sel == ACC_MASK);
   assign unused_wdata = ^reg_wdata[DATA_W-1:EV_W];

   chan_irq_status #(.NUM_CHAN(NUM_CHAN)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_done  (tx_done),
      .rx_done  (rx_done),
      .clr_en   (st_wr),
      .clr_bits (reg_wdata[EV_W-1:0]),
      .st_q     (st_q),
      .st_d     (st_d),
      .any_evt  (any_evt)
   );

   chan_irq_mask #(.EV_W(EV_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mk_wr),
      .wr_bits (reg_wdata[EV_W-1:0]),
      .mk_q    (mk_q),
      .mk_d    (mk_d)
   );

   // Evaluation looks at the values after this cycle's updates
   assign eval = st_wr || mk_wr || any_evt;
   assign pend = |(st_d & mk_d);

   chan_irq_line #(.CLR_THRESH(CLR_THRESH)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .eval  (eval),
      .pend  (pend),
      .irq   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         ACC_STATUS: reg_rdata[EV_W-1:0] = st_q;
         ACC_MASK:   reg_rdata[EV_W-1:0] = mk_q;
         default:    reg_rdata = '0;
      endcase
   end

   // R9: upper read bits are always zero
   a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:EV_W] == '0);

   // R9: an unmapped write leaves status and mask alone
   a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == ACC_NONE && !any_evt) |=> ($stable(st_q) && $stable(mk_q)));

endmodule

// File: tb/chan_irq_ctrl_bench.sv
module chan_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tx_done = '0;
   logic [3:0]  rx_done = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic        irq;
      logic [31:0] rd;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   // Reference state derived from the requirements
   logic [7:0] m_st = '0;
   logic [7:0] m_mk = '0;
   int         m_cnt = 0;
   logic       m_irq = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_irq_ctrl u_chan_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_done   (tx_done),
      .rx_done   (rx_done),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic [3:0] tx, input logic [3:0] rx, input bit wr,
                       input logic [7:0] addr, input logic [31:0] wd, input string req);
      logic [7:0] setv, clrv;
      bit         ev;
      exp_t       e;
      @(negedge clk);
      tx_done = tx; rx_done = rx; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
      setv = {rx, tx};                          // R1 bits 3..0, R2 bits 7..4
      clrv = (wr && addr == 8'h00) ? wd[7:0] : 8'h00;
      m_st = (m_st & ~clrv) | setv;             // R7 set wins
      if (wr && addr == 8'h10) m_mk = wd[7:0];
      ev = (wr && (addr == 8'h00 || addr == 8'h10)) || (setv != 0);
      if (ev) begin
         if ((m_st & m_mk) != 0) m_irq = 1'b1;
         else begin
            m_cnt++;
            if (m_cnt == 3) begin m_irq = 1'b0; m_cnt = 0; end
         end
      end
      e.irq = m_irq;
      e.rd  = (addr == 8'h00) ? {24'h0, m_st} : (addr == 8'h10) ? {24'h0, m_mk} : 32'h0;
      e.req = req;
      exp_q.push_back(e);
   endtask

   // Monitor: compares each queued result one step after the active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.req, "irq", {31'h0, irq}, {31'h0, e.irq});
            chk(e.req, "rdata", reg_rdata, e.rd);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      reg_addr = 8'h00; #1;
      chk("R8", "reset irq", {31'h0, irq}, 32'h0);
      chk("R8", "reset status", reg_rdata, 32'h0);
      reg_addr = 8'h10; #1;
      chk("R8", "reset mask", reg_rdata, 32'h0);
      rst_n = 1'b1;

      step(4'h0, 4'h0, 1, 8'h10, 32'h0000_00FF, "R4");   // cnt 1
      step(4'h4, 4'h0, 0, 8'h00, 32'h0, "R1");           // status 0x04, irq up
      step(4'h0, 4'h2, 0, 8'h00, 32'h0, "R2");           // status 0x24
      step(4'h0, 4'h0, 1, 8'h00, 32'h0000_0004, "R3");   // status 0x20
      step(4'h0, 4'h0, 1, 8'h00, 32'h0000_0020, "R6");   // empty, cnt 2
      repeat (3) step(4'h0, 4'h0, 0, 8'h00, 32'h0, "R10");
      step(4'h0, 4'h0, 0, 8'h10, 32'h0, "R10");
      step(4'h0, 4'h0, 1, 8'h10, 32'h0000_000F, "R6");   // cnt 3, irq down
      step(4'h0, 4'h8, 0, 8'h00, 32'h0, "R5");           // masked, cnt 1
      step(4'h0, 4'h0, 1, 8'h10, 32'h0000_00F0, "R5");   // unmasked, irq up
      step(4'h0, 4'h8, 1, 8'h00, 32'h0000_0080, "R7");   // set beats clear
      step(4'h0, 4'h0, 1, 8'h10, 32'hFFFF_FF00, "R9");   // mask 0, cnt 2
      step(4'h0, 4'h0, 1, 8'h44, 32'h0000_00FF, "R9");   // unmapped, no eval
      step(4'h0, 4'h0, 0, 8'h00, 32'h0, "R9");
      step(4'h0, 4'h0, 1, 8'h10, 32'h0, "R6");           // cnt 3, irq down
      step(4'hF, 4'hF, 0, 8'h00, 32'h0, "R1");           // all set, masked
      step(4'h0, 4'h0, 1, 8'h10, 32'h0000_0001, "R5");   // irq up
      step(4'h1, 4'h0, 1, 8'h00, 32'h0000_00FF, "R7");   // bit 0 survives
      step(4'h0, 4'h0, 1, 8'h00, 32'h0000_0001, "R6");   // cnt 2
      step(4'h0, 4'h0, 1, 8'h00, 32'h0, "R6");           // zero write, cnt 3
      repeat (2) step(4'h0, 4'h0, 0, 8'h10, 32'h0, "R10");
      step(4'h0, 4'h0, 0, 8'h00, 32'h0, "R10");

      @(negedge clk);
      tx_done = '0; rx_done = '0; reg_wr = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule